// File: doc/BRIEF.md
# Programmable flag offset loader

This block holds the two threshold offsets that a FIFO uses for its almost-empty and almost-full warnings, and it updates them at run time. One select pin does double duty. Its level while master reset is held chooses the default value of both offsets and also fixes how they can be reprogrammed until the next reset. A low level gives defaults of 127 with a parallel load port. A high level gives defaults of 1023 with a one-bit serial load port.

After reset, the select pin gates all offset traffic. In serial mode each qualified clock edge places one bit of the serial input into a chain. The chain holds the almost-empty offset first and the almost-full offset after it, each LSB first. In parallel mode each qualified write stores a whole word, and the writes alternate between the two offsets. Either mode can read the offsets back through a parallel port that alternates the same way. Two combinational flags compare a supplied fill count against the offsets.

All sequential logic runs on one clock, which serves as both the write clock and the read clock.

Top module: `flag_offset_loader`

## Requirements
- R1: If `prog_sel` is 0 on a clock edge with `mrst` high, then after that edge both offsets are 127 and `serial_mode` is 0 (parallel loading).
- R2: If `prog_sel` is 1 on a clock edge with `mrst` high, then after that edge both offsets are 1023 and `serial_mode` is 1 (serial loading).
- R3: In serial mode, an edge with `prog_sel` and `ser_en` both 1 writes `ser_in` into the next chain bit. Chain bits 0 to OFFSET_W-1 are the almost-empty offset, LSB first, and bits OFFSET_W to 2*OFFSET_W-1 are the almost-full offset, LSB first. After bit 2*OFFSET_W-1 the position returns to bit 0, and master reset returns it to bit 0.
- R4: In serial mode, an edge with `ser_en` at 0 or `prog_sel` at 0 leaves both offsets unchanged.
- R5: `serial_mode` changes only during master reset. Toggling `prog_sel` afterwards does not alter it.
- R6: Only the method chosen at reset writes the offsets. In parallel mode `ser_en` and `ser_in` have no effect, and in serial mode `wr_en` and `wr_data` have no effect.
- R7: In parallel mode, edges with `prog_sel` and `wr_en` both 1 store `wr_data` into the almost-empty offset, then into the almost-full offset, alternating from there. Master reset restarts the order at the almost-empty offset. `wr_en` with `prog_sel` at 0 writes nothing.
- R8: An edge with `prog_sel` and `rd_en` both 1 (in either mode) sets `rd_valid` to 1 for the next cycle. In that cycle `rd_data` shows the almost-empty offset, then the almost-full offset on the next such read, alternating, with the value held before that edge. On any other edge `rd_valid` becomes 0 and `rd_data` keeps its value.
- R9: `almost_empty` is 1 exactly when `fill_cnt` is at or below the almost-empty offset, with no clock delay.
- R10: `almost_full` is 1 exactly when DEPTH minus `fill_cnt` is at or below the almost-full offset, with no clock delay.
- R11: While `mrst` is high no offset is written and no readback occurs. After reset `rd_valid` is 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by write and read sides |
| mrst | input | 1 | Synchronous master reset, active high |
| prog_sel | input | 1 | Default/method select during reset; offset access gate afterwards |
| ser_en | input | 1 | Serial shift enable |
| ser_in | input | 1 | Serial offset bit |
| wr_en | input | 1 | Parallel offset write strobe |
| wr_data | input | OFFSET_W | Parallel offset write word |
| rd_en | input | 1 | Offset readback strobe |
| fill_cnt | input | $clog2(DEPTH+1) | Current FIFO word count |
| rd_data | output | OFFSET_W | Offset readback word |
| rd_valid | output | 1 | Readback word valid this cycle |
| serial_mode | output | 1 | 1 when serial loading was chosen at reset |
| almost_empty | output | 1 | Fill count at or below the almost-empty offset |
| almost_full | output | 1 | Free space at or below the almost-full offset |

## Verification
The hardest state to reach is a serial chain position that has wrapped past the last almost-full bit into the almost-empty offset while some earlier shift edges were withheld. Withholding happens either through `ser_en` low or through `prog_sel` low. The stimulus gets there by shifting more than 2*OFFSET_W bits with gaps placed between them. It then applies a mid-sequence master reset and shifts a full chain again, so a wrong restart shows in the readback values and in the flags. For parallel mode, the stimulus issues a write and a readback on the same edge, which exposes whether readback returns the value held before the write.

// File: rtl/ofl_pkg.sv
package ofl_pkg;

  typedef enum logic {
    LOAD_PARALLEL = 1'b0,
    LOAD_SERIAL   = 1'b1
  } load_mode_e;

  // Fill count at or below the almost-empty threshold
  function automatic logic fill_within(input int unsigned fill,
                                       input int unsigned off);
    return fill <= off;
  endfunction

  // Remaining space at or below the almost-full threshold
  function automatic logic space_within(input int unsigned depth,
                                        input int unsigned fill,
                                        input int unsigned off);
    int unsigned room;
    room = (fill >= depth) ? 0 : depth - fill;
    return room <= off;
  endfunction

endpackage

// File: rtl/ofl_step_ptr.sv
// Modulo-N position counter, cleared by master reset
module ofl_step_ptr #(
  parameter int N = 2,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic          adv,
  output logic [IW-1:0] idx
);

  localparam logic [IW-1:0] LAST = IW'(N - 1);

  always_ff @(posedge clk) begin
    if (mrst)
      idx <= '0;
    else if (adv)
      idx <= (idx == LAST) ? '0 : idx + 1'b1;
  end

endmodule

// File: rtl/ofl_offset_regs.sv
// Offset storage: one chain of 2*W bits, low half almost-empty, high half almost-full
module ofl_offset_regs
  import ofl_pkg::*;
#(
  parameter int W       = 10,
  parameter int DEF_PAR = 127,
  parameter int DEF_SER = 1023,
  localparam int CHAIN  = 2 * W,
  localparam int BW     = $clog2(CHAIN)
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic          sel_at_reset,
  input  logic          ser_shift,
  input  logic [BW-1:0] bit_idx,
  input  logic          ser_bit,
  input  logic          par_wr,
  input  logic          par_hi,
  input  logic [W-1:0]  par_data,
  output load_mode_e    mode,
  output logic [W-1:0]  ae_off,
  output logic [W-1:0]  af_off
);

  localparam logic [W-1:0] DEF_P = W'(DEF_PAR);
  localparam logic [W-1:0] DEF_S = W'(DEF_SER);

  logic [CHAIN-1:0] chain_q;
  logic [CHAIN-1:0] chain_d;
  logic [CHAIN-1:0] chain_def;

  assign chain_def = sel_at_reset ? {DEF_S, DEF_S} : {DEF_P, DEF_P};

  for (genvar i = 0; i < CHAIN; i++) begin : g_bit
    localparam bit HALF = (i >= W);
    localparam int K    = i % W;
    logic hit_ser;
    logic hit_par;
    assign hit_ser = ser_shift && (bit_idx == BW'(i));
    assign hit_par = par_wr && (par_hi == HALF);
    assign chain_d[i] = hit_ser ? ser_bit :
                        hit_par ? par_data[K] : chain_q[i];
  end

  always_ff @(posedge clk) begin
    if (mrst) begin
      chain_q <= chain_def;
      mode    <= sel_at_reset ? LOAD_SERIAL : LOAD_PARALLEL;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign ae_off = chain_q[W-1:0];
  assign af_off = chain_q[CHAIN-1:W];

endmodule

// File: rtl/ofl_flag_cmp.sv
module ofl_flag_cmp #(
  parameter int W     = 10,
  parameter int DEPTH = 1024,
  parameter int CNT_W = 11
) (
  input  logic [CNT_W-1:0] fill_cnt,
  input  logic [W-1:0]     ae_off,
  input  logic [W-1:0]     af_off,
  output logic             almost_empty,
  output logic             almost_full
);

  assign almost_empty = ofl_pkg::fill_within(32'(fill_cnt), 32'(ae_off));
  assign almost_full  = ofl_pkg::space_within(32'(DEPTH), 32'(fill_cnt), 32'(af_off));

endmodule

// File: rtl/flag_offset_loader.sv
module flag_offset_loader
  import ofl_pkg::*;
#(
  parameter int OFFSET_W       = 10,
  parameter int DEPTH          = 1024,
  parameter int DEF_PAR_OFFSET = 127,
  parameter int DEF_SER_OFFSET = 1023,
  localparam int CNT_W         = $clog2(DEPTH + 1),
  localparam int CHAIN_LEN     = 2 * OFFSET_W,
  localparam int BIT_W         = $clog2(CHAIN_LEN)
) (
  input  logic                clk,
  input  logic                mrst,
  input  logic                prog_sel,
  input  logic                ser_en,
  input  logic                ser_in,
  input  logic                wr_en,
  input  logic [OFFSET_W-1:0] wr_data,
  input  logic                rd_en,
  input  logic [CNT_W-1:0]    fill_cnt,
  output logic [OFFSET_W-1:0] rd_data,
  output logic                rd_valid,
  output logic                serial_mode,
  output logic                almost_empty,
  output logic                almost_full
);

  load_mode_e          mode;
  logic [OFFSET_W-1:0] ae_off;
  logic [OFFSET_W-1:0] af_off;
  logic [BIT_W-1:0]    bit_idx;
  logic                wr_half;
  logic                rd_half;

  // Named events, also observed by the bound checker
  logic serial_shift_ev;
  logic par_write_ev;
  logic readback_ev;

  assign serial_shift_ev = !mrst && prog_sel && ser_en && (mode == LOAD_SERIAL);
  assign par_write_ev    = !mrst && prog_sel && wr_en  && (mode == LOAD_PARALLEL);
  assign readback_ev     = !mrst && prog_sel && rd_en;
  assign serial_mode     = (mode == LOAD_SERIAL);

  ofl_step_ptr #(.N(CHAIN_LEN)) u_ser_pos (
    .clk (clk),
    .mrst(mrst),
    .adv (serial_shift_ev),
    .idx (bit_idx)
  );

  ofl_step_ptr #(.N(2)) u_wr_half (
    .clk (clk),
    .mrst(mrst),
    .adv (par_write_ev),
    .idx (wr_half)
  );

  ofl_step_ptr #(.N(2)) u_rd_half (
    .clk (clk),
    .mrst(mrst),
    .adv (readback_ev),
    .idx (rd_half)
  );

  ofl_offset_regs #(
    .W      (OFFSET_W),
    .DEF_PAR(DEF_PAR_OFFSET),
    .DEF_SER(DEF_SER_OFFSET)
  ) u_regs (
    .clk         (clk),
    .mrst        (mrst),
    .sel_at_reset(prog_sel),
    .ser_shift   (serial_shift_ev),
    .bit_idx     (bit_idx),
    .ser_bit     (ser_in),
    .par_wr      (par_write_ev),
    .par_hi      (wr_half),
    .par_data    (wr_data),
    .mode        (mode),
    .ae_off      (ae_off),
    .af_off      (af_off)
  );

  ofl_flag_cmp #(
    .W    (OFFSET_W),
    .DEPTH(DEPTH),
    .CNT_W(CNT_W)
  ) u_flags (
    .fill_cnt    (fill_cnt),
    .ae_off      (ae_off),
    .af_off      (af_off),
    .almost_empty(almost_empty),
    .almost_full (almost_full)
  );

  always_ff @(posedge clk) begin
    if (mrst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= readback_ev;
      if (readback_ev)
        rd_data <= rd_half ? af_off : ae_off;
    end
  end

endmodule

// File: rtl/ofl_checker.sv
module ofl_checker #(
  parameter int W     = 10,
  parameter int BW    = 5,
  parameter int CNT_W = 11,
  parameter int DEF_P = 127,
  parameter int DEF_S = 1023
) (
  input logic             clk,
  input logic             mrst,
  input logic             prog_sel,
  input logic             ser_en,
  input logic             ser_in,
  input logic             wr_en,
  input logic [W-1:0]     wr_data,
  input logic [CNT_W-1:0] fill_cnt,
  input logic             serial_mode,
  input logic [W-1:0]     ae_off,
  input logic [W-1:0]     af_off,
  input logic [BW-1:0]    bit_idx,
  input logic             wr_half,
  input logic             rd_half,
  input logic             serial_shift_ev,
  input logic             par_write_ev,
  input logic             readback_ev,
  input logic             rd_valid,
  input logic [W-1:0]     rd_data,
  input logic             almost_empty
);

  logic [2*W-1:0] chain;
  assign chain = {af_off, ae_off};

  p_defaults_par_r1: assert property (@(posedge clk)
    mrst && !prog_sel |=> (ae_off == W'(DEF_P)) && (af_off == W'(DEF_P)) && !serial_mode);

  p_defaults_ser_r2: assert property (@(posedge clk)
    mrst && prog_sel |=> (ae_off == W'(DEF_S)) && (af_off == W'(DEF_S)) && serial_mode);

  p_serial_bit_r3: assert property (@(posedge clk) disable iff (mrst)
    serial_shift_ev |=> chain[$past(bit_idx)] == $past(ser_in));

  p_chain_wrap_r3: assert property (@(posedge clk) disable iff (mrst)
    serial_shift_ev && (bit_idx == BW'(2*W-1)) |=> bit_idx == '0);

  p_serial_hold_r4: assert property (@(posedge clk) disable iff (mrst)
    serial_mode && !(prog_sel && ser_en) |=> $stable(chain));

  p_mode_fixed_r5: assert property (@(posedge clk) disable iff (mrst)
    !$past(mrst) |-> $stable(serial_mode));

  p_parallel_ignores_serial_r6: assert property (@(posedge clk) disable iff (mrst)
    !serial_mode && !(prog_sel && wr_en) |=> $stable(chain));

  p_par_write_ae_r7: assert property (@(posedge clk) disable iff (mrst)
    par_write_ev && !wr_half |=> ae_off == $past(wr_data));

  p_par_write_af_r7: assert property (@(posedge clk) disable iff (mrst)
    par_write_ev && wr_half |=> af_off == $past(wr_data));

  p_readback_r8: assert property (@(posedge clk) disable iff (mrst)
    readback_ev |=> rd_valid && (rd_data == ($past(rd_half) ? $past(af_off) : $past(ae_off))));

  p_readback_idle_r8: assert property (@(posedge clk) disable iff (mrst)
    !readback_ev |=> !rd_valid && $stable(rd_data));

  p_empty_floor_r9: assert property (@(posedge clk) disable iff (mrst)
    fill_cnt == '0 |-> almost_empty);

  p_reset_quiet_r11: assert property (@(posedge clk)
    mrst |=> !rd_valid && (rd_data == '0));

endmodule

bind flag_offset_loader ofl_checker #(
  .W    (OFFSET_W),
  .BW   (BIT_W),
  .CNT_W(CNT_W),
  .DEF_P(DEF_PAR_OFFSET),
  .DEF_S(DEF_SER_OFFSET)
) u_ofl_checker (
  .clk            (clk),
  .mrst           (mrst),
  .prog_sel       (prog_sel),
  .ser_en         (ser_en),
  .ser_in         (ser_in),
  .wr_en          (wr_en),
  .wr_data        (wr_data),
  .fill_cnt       (fill_cnt),
  .serial_mode    (serial_mode),
  .ae_off         (ae_off),
  .af_off         (af_off),
  .bit_idx        (bit_idx),
  .wr_half        (wr_half),
  .rd_half        (rd_half),
  .serial_shift_ev(serial_shift_ev),
  .par_write_ev   (par_write_ev),
  .readback_ev    (readback_ev),
  .rd_valid       (rd_valid),
  .rd_data        (rd_data),
  .almost_empty   (almost_empty)
);

// File: tb/flag_offset_loader_bench.sv
`timescale 1ns/100ps
module flag_offset_loader_bench;

  localparam int OW    = 10;
  localparam int DEPTH = 1024;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          mrst = 1'b1;
  logic          prog_sel = 1'b0;
  logic          ser_en = 1'b0;
  logic          ser_in = 1'b0;
  logic          wr_en = 1'b0;
  logic [OW-1:0] wr_data = '0;
  logic          rd_en = 1'b0;
  logic [CW-1:0] fill_cnt = '0;
  logic [OW-1:0] rd_data;
  logic          rd_valid;
  logic          serial_mode;
  logic          almost_empty;
  logic          almost_full;

  always #2.5 clk = ~clk;

  flag_offset_loader u_flag_offset_loader (
    .clk(clk), .mrst(mrst), .prog_sel(prog_sel), .ser_en(ser_en),
    .ser_in(ser_in), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .fill_cnt(fill_cnt), .rd_data(rd_data), .rd_valid(rd_valid),
    .serial_mode(serial_mode), .almost_empty(almost_empty),
    .almost_full(almost_full)
  );

  // Behavioural reference state
  int m_ser, m_ae, m_af, m_pos, m_wturn, m_rturn, m_rdv, m_rdd;
  int writes_seen[$];
  bit started = 0;
  bit done = 0;
  int n_cmp = 0;
  int n_bad = 0;
  string phase = "R11";

  always @(posedge clk) begin
    started = 1;
    if (mrst) begin
      m_ser = prog_sel;
      m_ae = prog_sel ? 1023 : 127;
      m_af = m_ae;
      m_pos = 0; m_wturn = 0; m_rturn = 0; m_rdv = 0; m_rdd = 0;
    end else begin
      // readback sees values before this edge's write
      if (prog_sel && rd_en) begin
        m_rdd = (m_rturn == 0) ? m_ae : m_af;
        m_rdv = 1;
        m_rturn = 1 - m_rturn;
      end else begin
        m_rdv = 0;
      end
      if (m_ser == 1 && prog_sel && ser_en) begin
        if (m_pos < OW)
          m_ae = (m_ae & ~(1 << m_pos)) | (int'(ser_in) << m_pos);
        else
          m_af = (m_af & ~(1 << (m_pos - OW))) | (int'(ser_in) << (m_pos - OW));
        m_pos = (m_pos + 1) % (2 * OW);
      end
      if (m_ser == 0 && prog_sel && wr_en) begin
        writes_seen.push_back(int'(wr_data));
        if (m_wturn == 0) m_ae = int'(wr_data); else m_af = int'(wr_data);
        m_wturn = 1 - m_wturn;
      end
    end
  end

  task automatic cmp(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", phase, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (started && !done) begin
      int room;
      room = (int'(fill_cnt) >= DEPTH) ? 0 : DEPTH - int'(fill_cnt);
      cmp("serial_mode", int'(serial_mode), m_ser);
      cmp("rd_valid", int'(rd_valid), m_rdv);
      cmp("rd_data", int'(rd_data), m_rdd);
      cmp("almost_empty R9", int'(almost_empty), int'(int'(fill_cnt) <= m_ae));
      cmp("almost_full R10", int'(almost_full), int'(room <= m_af));
    end
  end

  task automatic drive(input logic ps, input logic se, input logic si,
                       input logic we, input int wd, input logic re, input int fc);
    @(negedge clk);
    mrst = 1'b0; prog_sel = ps; ser_en = se; ser_in = si;
    wr_en = we; wr_data = OW'(wd); rd_en = re; fill_cnt = CW'(fc);
  endtask

  task automatic do_reset(input logic sel, input int n);
    @(negedge clk);
    mrst = 1'b1; prog_sel = sel; ser_en = 1'b1; wr_en = 1'b1; rd_en = 1'b1;
    repeat (n) @(negedge clk);
    mrst = 1'b0; prog_sel = 1'b0; ser_en = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic read_both(input int fc);
    drive(1, 0, 0, 0, 0, 1, fc);
    drive(1, 0, 0, 0, 0, 1, fc);
    drive(0, 0, 0, 0, 0, 0, fc);
  endtask

  task automatic shift_word(input int pattern, input int nbits, input bit gaps);
    for (int i = 0; i < nbits; i++) begin
      drive(1, 1, logic'((pattern >> (i % 20)) & 1), 1, 1000 - i, 0, i * 37);
      if (gaps && (i % 3 == 1)) drive(1, 0, 1, 0, 0, 0, 500);
      if (gaps && (i % 5 == 2)) drive(0, 1, 1, 0, 0, 0, 900);
    end
  endtask

  initial begin
    // R1 with R11: reset low selects parallel and 127 defaults
    phase = "R11";
    do_reset(0, 3);
    phase = "R1";
    read_both(0);
    for (int f = 125; f <= 129; f++) drive(0, 0, 0, 0, 0, 0, f);
    phase = "R10";
    for (int f = DEPTH - 129; f <= DEPTH; f++) drive(0, 0, 0, 0, 0, 0, f);

    // R7: alternating parallel writes, plus a write without the gate
    phase = "R7";
    drive(0, 0, 0, 1, 11, 0, 12);
    drive(1, 0, 0, 1, 5, 0, 5);
    drive(1, 0, 0, 1, 900, 0, 124);
    read_both(6);
    drive(1, 0, 0, 1, 33, 1, 33);   // write ae while reading back ae
    drive(1, 0, 0, 0, 0, 1, 34);
    drive(1, 0, 0, 1, 1023, 1, 0);
    read_both(1);
    phase = "R9";
    for (int f = 30; f <= 36; f++) drive(0, 0, 0, 0, 0, 0, f);
    phase = "R10";
    for (int f = 0; f <= 3; f++) drive(0, 0, 0, 0, 0, 0, f);

    // R6: serial strobes do nothing in parallel mode
    phase = "R6";
    for (int i = 0; i < 25; i++) drive(1, 1, logic'(i & 1), 0, 0, 0, 40);
    read_both(40);

    // R5: select toggles after reset leave the method alone
    phase = "R5";
    for (int i = 0; i < 6; i++) drive(logic'(i & 1), 0, 0, 0, 0, 0, 100);

    // R2: reset high selects serial and 1023 defaults
    phase = "R2";
    do_reset(1, 2);
    read_both(1000);
    phase = "R10";
    drive(0, 0, 0, 0, 0, 0, 1);
    drive(0, 0, 0, 0, 0, 0, 0);

    // R6: parallel writes do nothing in serial mode
    phase = "R6";
    for (int i = 0; i < 4; i++) drive(1, 0, 0, 1, 3 + i, 0, 50);
    read_both(50);

    // R4 and R3: gapped serial load, then wrap into the low half
    phase = "R4";
    shift_word(32'h5A3C7, 20, 1);
    phase = "R3";
    read_both(200);
    shift_word(32'h00015, 7, 0);
    read_both(400);
    for (int f = 0; f < 8; f++) drive(0, 0, 0, 0, 0, 0, f * 150);

    // R3: mid-chain reset restarts the position at bit 0
    phase = "R3";
    shift_word(32'hFFFFF, 9, 0);
    do_reset(1, 1);
    shift_word(32'h2B1E4, 20, 0);
    read_both(300);

    // R8: read strobe without the gate is ignored
    phase = "R8";
    drive(0, 0, 0, 0, 0, 1, 10);
    drive(0, 0, 0, 0, 0, 1, 10);
    read_both(10);

    // R1 again after serial use, with R11 on a reset held with strobes high
    phase = "R11";
    do_reset(0, 2);
    phase = "R1";
    read_both(127);
    drive(0, 0, 0, 0, 0, 0, 128);
    drive(0, 0, 0, 0, 0, 0, 0);

    @(negedge clk);
    #2;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule